// File: doc/BRIEF.md
# Error-Detecting Read Cache with Line Refetch

This block is a direct-mapped read cache placed between a requester and a simple main-memory port. Every stored tag and every stored 32-bit data word carries detection-only parity. The parity is generated when a line is filled and checked during the normal lookup. Main memory always holds a good copy of each line, so the cache never tries to repair a bad bit in place. When a lookup finds a parity mismatch on the tag or on the requested word, the controller drops the line, counts the event and fetches all four words again from memory. The requester still receives the correct word. The only sign of the upset is the added latency.

A requester presents a word address with `req_valid` while `req_ready` is high. It receives exactly one `rsp_valid` pulse carrying the data. On the memory side the cache holds `mem_req` with a line-aligned address. Memory answers with four `mem_ack` beats, which carry the words of the line in ascending order and need not be back to back.

A test port arms a pair of XOR masks. These masks corrupt the next line fill: the data mask hits word 0 and the tag mask hits the stored tag. The test port lets the recovery path be exercised on demand.

The controller has four states:

- IDLE: waiting for a request.
- LOOKUP: the arrays have been read and are being checked.
- FILL: the four words of a line are being collected from memory.
- REPLY: the word captured during the fill is returned.

Its transitions are:

- *accept*: IDLE to LOOKUP.
- *hit*: LOOKUP to IDLE, with the response given in the same cycle.
- *miss*: LOOKUP to FILL, taken when the line is invalid or the tag differs.
- *refetch*: LOOKUP to FILL, taken on a parity error. The line is invalidated and the counter is bumped.
- *beat*: FILL to FILL, one per acknowledged word.
- *last beat*: FILL to REPLY.
- *reply done*: REPLY to IDLE.

Top module: `refetch_cache`

## Requirements
- R1: After reset every line is invalid, `err_count` is 0, `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R2: A word address splits as offset in bits [1:0], line index in bits [7:2] and tag in the upper bits. On a miss the cache holds `mem_req` with `mem_addr` equal to the request address with its two offset bits cleared. `mem_addr` stays stable until four `mem_ack` beats have been taken, each beat writing the next word (0 to 3) of the line. With one beat per cycle, the requested word appears on `rsp_valid` in the 6th cycle after acceptance, and stalls between beats do not alter the data.
- R3: A hit with good parity raises `rsp_valid` in the first cycle after acceptance and starts no memory transfer. Every response is a single-cycle pulse.
- R4: After one fill, all four words of the line hit and return the memory contents.
- R5: A request with the same index but a different tag misses and replaces the line, so the previous tag then misses again.
- R6: Each data word carries one even-parity bit per byte. If any byte of the requested word of a valid, tag-matching line has an odd number of flipped bits, the error is detected. This holds for four flips spread over four different bytes. The line is refetched (6-cycle response, one more line fill), the correct word is returned, and `err_count` rises by exactly 1. The next read of that word hits.
- R7: The tag carries one even-parity bit per 8-bit slice. An odd flip count in a slice of a valid line's stored tag is detected on any lookup of that index. It is recovered like R6: refetch, correct data, `err_count` plus 1.
- R8: Two flipped bits inside one byte escape detection. The read hits in one cycle, returns the stored corrupted value, and `err_count` does not change.
- R9: Pulsing `inj_arm` latches both masks. They apply to the next line fill only: the data mask to word 0 and the tag mask to the tag. Fills after that one store clean data.
- R10: `err_count` is a saturating counter. Once it reaches its all-ones value, further detected errors leave it unchanged, while recovery still returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_addr | input | AW | Word address of the read |
| rsp_valid | output | 1 | One-cycle pulse with returned data |
| rsp_data | output | 32 | Returned word |
| mem_req | output | 1 | Line fetch in progress |
| mem_addr | output | AW | Line-aligned word address of the fetch |
| mem_ack | input | 1 | Memory delivers one word this cycle |
| mem_data | input | 32 | Word delivered by memory |
| inj_arm | input | 1 | Latch the fault masks for the next fill |
| inj_data_flip | input | 32 | XOR mask for word 0 of the next fill |
| inj_tag_flip | input | AW-8 | XOR mask for the tag of the next fill |
| err_count | output | CNT_W | Saturating count of detected errors |

## Verification
The bench keeps the default geometry: 20-bit word addresses, 64 lines of 4 words, and a 12-bit tag split into two parity slices, so a partially filled slice is covered. It builds the block with a 3-bit error counter instead of 16 bits. Saturation is then reached after seven detected errors, which puts the R10 corner within a short run. The same bench would need tens of thousands of injections to reach that corner at the default width.

// File: rtl/refetch_cache_pkg.sv
package refetch_cache_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_REPLY
    } cache_state_t;

    // even parity per byte lane
    function automatic logic [LANES-1:0] lane_parity(input logic [WORD_W-1:0] w);
        logic [LANES-1:0] p;
        for (int i = 0; i < LANES; i++) begin
            p[i] = ^w[i*8 +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/rc_data_array.sv
module rc_data_array
    import refetch_cache_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int OFF_W = 2
) (
    input  logic                     clk,
    input  logic                     rd_en,
    input  logic [IDX_W+OFF_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]        rd_word,
    output logic                     rd_ok,
    input  logic                     wr_en,
    input  logic [IDX_W+OFF_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic [WORD_W-1:0]        wr_flip
);
    localparam int DEPTH = 1 << (IDX_W + OFF_W);
    localparam int ENT_W = WORD_W + LANES;

    logic [ENT_W-1:0] store [DEPTH];
    logic [ENT_W-1:0] rd_q;

    // parity is computed from the clean word, the flip mask lands on the data only
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= {lane_parity(wr_word), wr_word ^ wr_flip};
        end
        if (rd_en) begin
            rd_q <= store[rd_addr];
        end
    end

    assign rd_word = rd_q[WORD_W-1:0];
    assign rd_ok   = (lane_parity(rd_q[WORD_W-1:0]) == rd_q[ENT_W-1:WORD_W]);

endmodule

// File: rtl/rc_tag_array.sv
module rc_tag_array #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_ok,
    output logic               rd_valid,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [TAG_W-1:0]   wr_flip,
    input  logic               inval_en,
    input  logic [IDX_W-1:0]   inval_idx
);
    localparam int LINES  = 1 << IDX_W;
    localparam int SLICES = (TAG_W + 7) / 8;
    localparam int PAD_W  = SLICES * 8;
    localparam int ENT_W  = TAG_W + SLICES;

    logic [ENT_W-1:0] store [LINES];
    logic [ENT_W-1:0] rd_q;
    logic [LINES-1:0] valid_q;
    logic             rd_valid_q;

    logic [PAD_W-1:0]  wr_pad, rd_pad;
    logic [SLICES-1:0] wr_par, rd_par;

    always_comb begin
        wr_pad = '0;
        wr_pad[TAG_W-1:0] = wr_tag;
        rd_pad = '0;
        rd_pad[TAG_W-1:0] = rd_q[TAG_W-1:0];
    end

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        assign wr_par[s] = ^wr_pad[s*8 +: 8];
        assign rd_par[s] = ^rd_pad[s*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= {wr_par, wr_tag ^ wr_flip};
        end
        if (rd_en) begin
            rd_q <= store[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
            end else if (inval_en) begin
                valid_q[inval_idx] <= 1'b0;
            end
            if (rd_en) begin
                rd_valid_q <= valid_q[rd_idx];
            end
        end
    end

    assign rd_tag   = rd_q[TAG_W-1:0];
    assign rd_ok    = (rd_par == rd_q[ENT_W-1:TAG_W]);
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/rc_err_counter.sv
module rc_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && count != TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import refetch_cache_pkg::*;
#(
    parameter int AW    = 20,
    parameter int IDX_W = 6,
    parameter int OFF_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [AW-1:0]        req_addr,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 mem_req,
    output logic [AW-1:0]        mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_data,
    input  logic                 inj_arm,
    input  logic [WORD_W-1:0]    inj_data_flip,
    input  logic [AW-IDX_W-OFF_W-1:0] inj_tag_flip,
    output logic                 arr_rd_en,
    input  logic [WORD_W-1:0]    arr_word,
    input  logic                 arr_word_ok,
    input  logic [AW-IDX_W-OFF_W-1:0] arr_tag,
    input  logic                 arr_tag_ok,
    input  logic                 arr_valid,
    output logic                 dwr_en,
    output logic [IDX_W+OFF_W-1:0] dwr_addr,
    output logic [WORD_W-1:0]    dwr_flip,
    output logic                 twr_en,
    output logic [IDX_W-1:0]     line_idx,
    output logic [AW-IDX_W-OFF_W-1:0] line_tag,
    output logic [AW-IDX_W-OFF_W-1:0] twr_flip,
    output logic                 inval_en,
    output logic                 err_bump
);
    localparam int TAG_W = AW - IDX_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = '1;

    cache_state_t state_q, state_nx;

    logic [AW-1:0]     addr_q;
    logic [OFF_W-1:0]  beat_q;
    logic [WORD_W-1:0] word_q;
    logic              inj_pend_q;
    logic [WORD_W-1:0] inj_dmask_q;
    logic [TAG_W-1:0]  inj_tmask_q;

    logic [OFF_W-1:0]  off_q;
    logic              tag_match, lookup_hit, lookup_err, fill_beat, last_beat;

    assign off_q    = addr_q[OFF_W-1:0];
    assign line_idx = addr_q[OFF_W +: IDX_W];
    assign line_tag = addr_q[AW-1 -: TAG_W];

    assign tag_match  = (arr_tag == line_tag);
    assign lookup_hit = arr_valid && arr_tag_ok && tag_match && arr_word_ok;
    assign lookup_err = arr_valid && (!arr_tag_ok || (tag_match && !arr_word_ok));
    assign fill_beat  = (state_q == ST_FILL) && mem_ack;
    assign last_beat  = (beat_q == LAST_BEAT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = lookup_hit ? ST_IDLE : ST_FILL;
            ST_FILL:   if (mem_ack && last_beat) state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        arr_rd_en = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        mem_req   = 1'b0;
        dwr_en    = 1'b0;
        dwr_flip  = '0;
        twr_en    = 1'b0;
        twr_flip  = '0;
        inval_en  = 1'b0;
        err_bump  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                arr_rd_en = req_valid;
            end
            ST_LOOKUP: begin
                if (lookup_hit) begin
                    rsp_valid = 1'b1;
                    rsp_data  = arr_word;
                end else if (lookup_err) begin
                    inval_en = 1'b1;
                    err_bump = 1'b1;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                dwr_en  = mem_ack;
                if (inj_pend_q && beat_q == '0) dwr_flip = inj_dmask_q;
                twr_en  = mem_ack && last_beat;
                if (inj_pend_q) twr_flip = inj_tmask_q;
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_data  = word_q;
            end
            default: ;
        endcase
    end

    assign mem_addr = {line_tag, line_idx, {OFF_W{1'b0}}};
    assign dwr_addr = {line_idx, beat_q};

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            beat_q      <= '0;
            word_q      <= '0;
            inj_pend_q  <= 1'b0;
            inj_dmask_q <= '0;
            inj_tmask_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state_q == ST_LOOKUP) beat_q <= '0;
            if (fill_beat) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == off_q) word_q <= mem_data;
                if (last_beat) inj_pend_q <= 1'b0;
            end
            if (inj_arm) begin
                inj_pend_q  <= 1'b1;
                inj_dmask_q <= inj_data_flip;
                inj_tmask_q <= inj_tag_flip;
            end
        end
    end

endmodule

// File: rtl/refetch_cache.sv
module refetch_cache
    import refetch_cache_pkg::*;
#(
    parameter int AW    = 20,
    parameter int IDX_W = 6,
    parameter int OFF_W = 2,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [AW-1:0]             req_addr,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_data,
    output logic                      mem_req,
    output logic [AW-1:0]             mem_addr,
    input  logic                      mem_ack,
    input  logic [31:0]               mem_data,
    input  logic                      inj_arm,
    input  logic [31:0]               inj_data_flip,
    input  logic [AW-IDX_W-OFF_W-1:0] inj_tag_flip,
    output logic [CNT_W-1:0]          err_count
);
    localparam int TAG_W = AW - IDX_W - OFF_W;

    logic                    arr_rd_en, arr_word_ok, arr_tag_ok, arr_valid;
    logic [WORD_W-1:0]       arr_word, dwr_flip;
    logic [TAG_W-1:0]        arr_tag, line_tag, twr_flip;
    logic                    dwr_en, twr_en, inval_en, err_bump;
    logic [IDX_W+OFF_W-1:0]  dwr_addr;
    logic [IDX_W-1:0]        line_idx;

    rc_ctrl #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .inj_arm(inj_arm), .inj_data_flip(inj_data_flip), .inj_tag_flip(inj_tag_flip),
        .arr_rd_en(arr_rd_en), .arr_word(arr_word), .arr_word_ok(arr_word_ok),
        .arr_tag(arr_tag), .arr_tag_ok(arr_tag_ok), .arr_valid(arr_valid),
        .dwr_en(dwr_en), .dwr_addr(dwr_addr), .dwr_flip(dwr_flip),
        .twr_en(twr_en), .line_idx(line_idx), .line_tag(line_tag), .twr_flip(twr_flip),
        .inval_en(inval_en), .err_bump(err_bump)
    );

    rc_data_array #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk(clk),
        .rd_en(arr_rd_en), .rd_addr(req_addr[IDX_W+OFF_W-1:0]),
        .rd_word(arr_word), .rd_ok(arr_word_ok),
        .wr_en(dwr_en), .wr_addr(dwr_addr), .wr_word(mem_data), .wr_flip(dwr_flip)
    );

    rc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst_n(rst_n),
        .rd_en(arr_rd_en), .rd_idx(req_addr[OFF_W +: IDX_W]),
        .rd_tag(arr_tag), .rd_ok(arr_tag_ok), .rd_valid(arr_valid),
        .wr_en(twr_en), .wr_idx(line_idx), .wr_tag(line_tag), .wr_flip(twr_flip),
        .inval_en(inval_en), .inval_idx(line_idx)
    );

    rc_err_counter #(.CNT_W(CNT_W)) u_errs (
        .clk(clk), .rst_n(rst_n), .bump(err_bump), .count(err_count)
    );

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int AW    = 20,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // R2
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2
    fill_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_valid);

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != TOP) |=> (err_count == $past(err_count) ||
                                err_count == $past(err_count) + 1'b1));

    // R10
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == TOP) |=> (err_count == TOP));

endmodule

bind refetch_cache rc_checker #(.AW(AW), .CNT_W(CNT_W)) u_rc_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .err_count(err_count)
);

// File: tb/refetch_cache_test.sv
`timescale 1ns/1ps
module refetch_cache_test;
    localparam int AW    = 20;
    localparam int TAG_W = 12;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [AW-1:0]    req_addr = '0;
    logic             rsp_valid;
    logic [31:0]      rsp_data;
    logic             mem_req;
    logic [AW-1:0]    mem_addr;
    logic             mem_ack = 1'b0;
    logic [31:0]      mem_data = '0;
    logic             inj_arm = 1'b0;
    logic [31:0]      inj_data_flip = '0;
    logic [TAG_W-1:0] inj_tag_flip = '0;
    logic [CNT_W-1:0] err_count;

    int total = 0;
    int bad   = 0;
    int beats = 0;
    bit stall_en = 1'b0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       req_q [$];

    always #10 clk = ~clk;

    refetch_cache #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .inj_arm(inj_arm), .inj_data_flip(inj_data_flip), .inj_tag_flip(inj_tag_flip),
        .err_count(err_count)
    );

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        logic [31:0] x;
        x = {12'h0, a};
        return x * 32'h9E37_79B1 + 32'h0123_4567;
    endfunction

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
        return {tag[TAG_W-1:0], idx[5:0], off[1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // memory model
    initial begin
        int beat = 0;
        bit toggle = 1'b0;
        forever begin
            @(negedge clk);
            toggle = ~toggle;
            if (mem_req && beat < 4 && !(stall_en && toggle)) begin
                mem_ack  = 1'b1;
                mem_data = mem_word(mem_addr + AW'(beat));
                beat++;
                beats++;
            end else begin
                mem_ack = 1'b0;
                if (!mem_req) beat = 0;
            end
        end
    end

    // monitor: pops the scoreboard on each response
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected response", rsp_data, 0);
                end else begin
                    logic [31:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(rsp_data == e, r, "rsp_data", rsp_data, e);
                end
            end
        end
    end

    // driver: one read, returns cycles from acceptance to response
    task automatic do_read(input logic [AW-1:0] a, input logic [31:0] e,
                           input string req, output int lat);
        @(negedge clk);
        exp_q.push_back(e);
        req_q.push_back(req);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic arm(input logic [31:0] dm, input logic [TAG_W-1:0] tm);
        @(negedge clk);
        inj_arm = 1'b1;
        inj_data_flip = dm;
        inj_tag_flip = tm;
        @(negedge clk);
        inj_arm = 1'b0;
        inj_data_flip = '0;
        inj_tag_flip = '0;
    endtask

    // watchdog
    initial begin
        #(20 * 60000);
        if (!finished) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        int lat;
        int b0;
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check(err_count == 0, "R1", "err_count", err_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && err_count == 0, "R1", "after release", err_count, 0);

        // R2 miss fill
        a = mk(1, 5, 2);
        b0 = beats;
        do_read(a, mem_word(a), "R2", lat);
        check(lat == 6, "R2", "miss latency", lat, 6);
        check(beats - b0 == 4, "R2", "fill beats", beats - b0, 4);

        // R1 invalid-after-reset: first read of another line also misses
        a = mk(3, 9, 0);
        do_read(a, mem_word(a), "R1", lat);
        check(lat == 6, "R1", "cold line misses", lat, 6);

        // R3 / R4 hits on all four words
        b0 = beats;
        for (int o = 0; o < 4; o++) begin
            a = mk(1, 5, o);
            do_read(a, mem_word(a), "R4", lat);
            check(lat == 1, "R3", "hit latency", lat, 1);
        end
        check(beats == b0, "R3", "no memory traffic on hits", beats - b0, 0);

        // R5 conflict replacement
        a = mk(2, 5, 1);
        do_read(a, mem_word(a), "R5", lat);
        check(lat == 6, "R5", "conflict miss", lat, 6);
        a = mk(1, 5, 1);
        do_read(a, mem_word(a), "R5", lat);
        check(lat == 6, "R5", "evicted tag misses", lat, 6);

        // R2 stalled beats
        stall_en = 1'b1;
        a = mk(7, 20, 3);
        do_read(a, mem_word(a), "R2", lat);
        check(lat > 6, "R2", "stalled fill slower", lat, 7);
        stall_en = 1'b0;
        a = mk(7, 20, 0);
        do_read(a, mem_word(a), "R2", lat);
        check(lat == 1, "R2", "stalled fill stored", lat, 1);

        // R6 four flips in four bytes of word 0
        arm(32'h0101_0101, '0);
        a = mk(4, 30, 1);
        do_read(a, mem_word(a), "R9", lat);
        a = mk(4, 30, 0);
        b0 = beats;
        do_read(a, mem_word(a), "R6", lat);
        check(lat == 6, "R6", "refetch latency", lat, 6);
        check(beats - b0 == 4, "R6", "refetch beats", beats - b0, 4);
        check(err_count == 1, "R6", "err_count", err_count, 1);
        do_read(a, mem_word(a), "R6", lat);
        check(lat == 1, "R6", "repaired line hits", lat, 1);

        // R7 tag slice error (upper, partial slice)
        arm('0, 12'h400);
        a = mk(12'h5A3, 40, 2);
        do_read(a, mem_word(a), "R7", lat);
        do_read(a, mem_word(a), "R7", lat);
        check(lat == 6, "R7", "tag error refetch", lat, 6);
        check(err_count == 2, "R7", "err_count", err_count, 2);
        do_read(a, mem_word(a), "R7", lat);
        check(lat == 1, "R7", "repaired tag hits", lat, 1);

        // R8 two flips in one byte escape
        arm(32'h0000_0003, '0);
        a = mk(6, 50, 2);
        do_read(a, mem_word(a), "R8", lat);
        a = mk(6, 50, 0);
        do_read(a, mem_word(a) ^ 32'h3, "R8", lat);
        check(lat == 1, "R8", "undetected hit", lat, 1);
        check(err_count == 2, "R8", "err_count unchanged", err_count, 2);

        // R9 masks consumed by one fill
        a = mk(8, 51, 1);
        do_read(a, mem_word(a), "R9", lat);
        a = mk(8, 51, 0);
        do_read(a, mem_word(a), "R9", lat);
        check(lat == 1, "R9", "next fill clean", lat, 1);
        check(err_count == 2, "R9", "err_count unchanged", err_count, 2);

        // R10 saturation
        for (int i = 0; i < 6; i++) begin
            arm(32'h0000_0080, '0);
            a = mk(9 + i, 60, 1);
            do_read(a, mem_word(a), "R10", lat);
            a = mk(9 + i, 60, 0);
            do_read(a, mem_word(a), "R10", lat);
        end
        check(err_count == 7, "R10", "saturated", err_count, 7);
        arm(32'h8000_0000, '0);
        a = mk(30, 61, 1);
        do_read(a, mem_word(a), "R10", lat);
        a = mk(30, 61, 0);
        do_read(a, mem_word(a), "R10", lat);
        check(lat == 6, "R10", "refetch while saturated", lat, 6);
        check(err_count == 7, "R10", "stays saturated", err_count, 7);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all responses seen", exp_q.size(), 0);
        finished = 1'b1;
        summary();
    end

endmodule